// File: doc/BRIEF.md
# Line Whitening Scrambler with Blind Receive Alignment

This block whitens a serial code-group stream before line coding and strips the whitening again on the receive side. The transmit path combines each valid data bit by XOR with one bit of an 11-stage maximal-length pseudo-random sequence. The sequence repeats every 2047 bits. The receive path runs its own copy of the generator. It has no side channel to the transmitter, so it aligns that generator blindly from the idle stream.

While the transmitter sends idle, the plain data is all ones. In that case every received bit is the inverse of the sequence bit. Three received bits spaced like the generator taps therefore always XOR to one. The receiver counts such hypothesis ones. After eleven in a row it loads its generator from the inverted last eleven received bits, raises its lock flag and free-runs from then on. A light check watches the descrambled stream for recurring idle runs and drops lock when they stop appearing, which restarts the search.

Both directions take one bit per clock, qualified by a valid strobe, and produce registered outputs one clock later.

Top module: `line_scrambler`

## Requirements
- R1: While `rst_n` is low and after its release, `tx_dout_valid`, `rx_dout_valid` and `rx_locked` are 0 until qualifying input bits arrive.
- R2: For each clock with `tx_valid` high, `tx_dout` on the next clock equals `tx_din` XOR x(n), with `tx_dout_valid` high. The sequence follows x(n) = x(n-11) XOR x(n-9), the generator state starts at all ones after reset, and the first sequence bit after reset is 0.
- R3: Clocks with `tx_valid` low produce no `tx_dout_valid` and do not advance the transmit sequence.
- R4: The transmit sequence has period 2047 valid bits.
- R5: Once 11 bits have been received, each further received bit c(n) yields a hypothesis c(n) XOR c(n-9) XOR c(n-11). When 11 consecutive hypotheses are one, `rx_locked` rises on the clock after that bit. For an idle stream this happens on the 22nd received bit after reset.
- R6: No lock is declared before 22 valid bits have been received after reset.
- R7: While locked, `rx_dout` equals `rx_din` XOR the local sequence bit, which recovers the plain data sent by a matching transmitter. The first descrambled bit is the one after the acquiring bit.
- R8: `rx_dout_valid` is high only on the clock after a valid received bit that arrived while locked.
- R9: While locked, if `LOSS_LEN` (32) consecutive descrambled bits pass without a run of `IDLE_RUN` (10) descrambled ones completing, lock drops. The drop is visible on the same clock as that last bit's descrambled output.
- R10: After a drop the receiver searches again and relocks after a fresh run of 11 hypothesis ones. It then descrambles correctly.
- R11: A hypothesis zero restarts the count of consecutive hypothesis ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit data bit qualifier |
| tx_din | input | 1 | Plain transmit bit |
| tx_dout_valid | output | 1 | Whitened bit qualifier |
| tx_dout | output | 1 | Whitened transmit bit |
| rx_valid | input | 1 | Received bit qualifier |
| rx_din | input | 1 | Received whitened bit |
| rx_dout_valid | output | 1 | Descrambled bit qualifier (locked only) |
| rx_dout | output | 1 | Descrambled bit |
| rx_locked | output | 1 | Receive generator aligned |

## Verification
Loss of lock and descrambled output fall in the same cycle. The bit that exhausts the idle-run window is still descrambled and presented as valid, and `rx_locked` falls on that same edge. The bench provokes this with 12 idle ones followed by exactly 32 plain zeros. It then checks that `rx_dout_valid` is high and `rx_locked` low together after the 32nd zero, and that lock still holds after the 31st. The following relock stream places hypothesis zeros inside the first idle run, so lock is expected only at its 22nd bit, not earlier.

// File: rtl/scr_pkg.sv
// Shared constants and sequence arithmetic for the line scrambler.
// Assumes state bit i holds the sequence bit produced i+1 steps ago.
package scr_pkg;
    localparam int PRBS_W   = 11;
    localparam int PRBS_TAP = 9;

    typedef logic [PRBS_W-1:0] prbs_t;

    // Current sequence bit: x(n) = x(n-11) ^ x(n-9)
    function automatic logic prbs_bit(input prbs_t s);
        return s[PRBS_W-1] ^ s[PRBS_TAP-1];
    endfunction

    // State after emitting the current bit
    function automatic prbs_t prbs_next(input prbs_t s);
        return {s[PRBS_W-2:0], prbs_bit(s)};
    endfunction
endpackage

// File: rtl/scr_prbs_gen.sv
// Pseudo-random sequence generator with a load port.
// Presents the current sequence bit combinationally; steps on advance.
// Assumes load and advance are not needed in the same cycle (load wins).
module scr_prbs_gen
    import scr_pkg::*;
#(
    parameter prbs_t SEED = '1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    input  logic  load,
    input  prbs_t load_val,
    output logic  seq_bit
);
    prbs_t st;

    // State register: reset seed, alignment load, or one step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEED;
        end else if (load) begin
            st <= load_val;
        end else if (advance) begin
            st <= prbs_next(st);
        end
    end

    assign seq_bit = prbs_bit(st);
endmodule

// File: rtl/scr_tx_path.sv
// Transmit whitening: XOR each valid bit with the next sequence bit.
// Output is registered, one clock after the input bit.
module scr_tx_path
    import scr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit
);
    logic seq;

    scr_prbs_gen #(.SEED('1)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (in_valid),
        .load     (1'b0),
        .load_val ('0),
        .seq_bit  (seq)
    );

    // Output register for the whitened bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bit <= in_bit ^ seq;
            end
        end
    end
endmodule

// File: rtl/scr_rx_acquire.sv
// Blind alignment search on the received stream.
// Keeps the last PRBS_W received bits, forms tap hypotheses once the history
// is full, and flags detection on PRBS_W consecutive hypothesis ones.
// Assumes the plain stream is all ones (idle) while searching, so the load
// value is the inverted history including the current bit.
module scr_rx_acquire
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_valid,
    input  logic  bit_in,
    input  logic  searching,
    output logic  detect,
    output prbs_t load_val
);
    localparam int FILL_W = $clog2(PRBS_W + 1);
    localparam int HRUN_W = $clog2(PRBS_W);

    prbs_t              hist;
    logic [FILL_W-1:0]  fill;
    logic [HRUN_W-1:0]  hrun;
    prbs_t              hist_new;
    logic               hyp;
    logic               full;

    // Hypothesis and detection for the bit arriving this cycle
    always_comb begin
        hist_new = {hist[PRBS_W-2:0], bit_in};
        hyp      = bit_in ^ hist[PRBS_TAP-1] ^ hist[PRBS_W-1];
        full     = (fill == FILL_W'(PRBS_W));
        detect   = bit_valid && searching && full && hyp &&
                   (hrun == HRUN_W'(PRBS_W - 1));
        load_val = ~hist_new;
    end

    // History, fill level and hypothesis run bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            fill <= '0;
            hrun <= '0;
        end else if (bit_valid) begin
            hist <= hist_new;
            if (!full) begin
                fill <= fill + FILL_W'(1);
            end
            if (!searching || !full || !hyp || detect) begin
                hrun <= '0;
            end else begin
                hrun <= hrun + HRUN_W'(1);
            end
        end
    end
endmodule

// File: rtl/scr_lock_monitor.sv
// Lock health check on the descrambled stream.
// Expects a run of IDLE_RUN ones at least once in every LOSS_LEN bits;
// raises drop on the bit that exhausts the window without one.
module scr_lock_monitor #(
    parameter int IDLE_RUN = 10,
    parameter int LOSS_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic bit_valid,
    input  logic dbit,
    output logic drop
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam int GAP_W = $clog2(LOSS_LEN);

    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] run_n;
    logic [GAP_W-1:0] gap;
    logic             idle_seen;

    // Saturating run of ones and loss decision for this bit
    always_comb begin
        if (!dbit) begin
            run_n = '0;
        end else if (run == RUN_W'(IDLE_RUN)) begin
            run_n = run;
        end else begin
            run_n = run + RUN_W'(1);
        end
        idle_seen = (run_n == RUN_W'(IDLE_RUN));
        drop      = bit_valid && !idle_seen && (gap == GAP_W'(LOSS_LEN - 1));
    end

    // Run and gap counters; acquisition counts as a fresh idle run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
            gap <= '0;
        end else if (arm) begin
            run <= RUN_W'(IDLE_RUN);
            gap <= '0;
        end else if (bit_valid) begin
            run <= run_n;
            if (idle_seen || drop) begin
                gap <= '0;
            end else begin
                gap <= gap + GAP_W'(1);
            end
        end
    end
endmodule

// File: rtl/line_scrambler.sv
// Top level: transmit whitening plus receive descrambling with blind
// alignment. One bit per clock each way, valid-qualified, outputs registered.
// Assumes the far transmitter sends idle (plain ones) long enough to align.
module line_scrambler
    import scr_pkg::*;
#(
    parameter int IDLE_RUN = 10,
    parameter int LOSS_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_din,
    output logic tx_dout_valid,
    output logic tx_dout,
    input  logic rx_valid,
    input  logic rx_din,
    output logic rx_dout_valid,
    output logic rx_dout,
    output logic rx_locked
);
    logic  locked_q;
    logic  rx_bit_locked;
    logic  detect;
    logic  drop;
    logic  rx_seq;
    logic  rx_plain;
    prbs_t load_val;

    assign rx_bit_locked = rx_valid && locked_q;
    assign rx_plain      = rx_din ^ rx_seq;
    assign rx_locked     = locked_q;

    scr_tx_path u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_bit    (tx_din),
        .out_valid (tx_dout_valid),
        .out_bit   (tx_dout)
    );

    scr_rx_acquire u_acq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (rx_valid),
        .bit_in    (rx_din),
        .searching (!locked_q),
        .detect    (detect),
        .load_val  (load_val)
    );

    scr_prbs_gen #(.SEED('1)) u_rx_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (rx_bit_locked),
        .load     (detect),
        .load_val (load_val),
        .seq_bit  (rx_seq)
    );

    scr_lock_monitor #(.IDLE_RUN(IDLE_RUN), .LOSS_LEN(LOSS_LEN)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (detect),
        .bit_valid (rx_bit_locked),
        .dbit      (rx_plain),
        .drop      (drop)
    );

    // Lock flag: set on acquisition, cleared by the health check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (detect) begin
            locked_q <= 1'b1;
        end else if (drop) begin
            locked_q <= 1'b0;
        end
    end

    // Descrambled output register, valid only for locked bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dout_valid <= 1'b0;
            rx_dout       <= 1'b0;
        end else begin
            rx_dout_valid <= rx_bit_locked;
            if (rx_bit_locked) begin
                rx_dout <= rx_plain;
            end
        end
    end
endmodule

// File: rtl/scr_checker.sv
// Port-level timing properties of the line scrambler, bound to the top.
module scr_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_dout_valid,
    input logic rx_valid,
    input logic rx_dout_valid,
    input logic rx_locked
);
    // R2: a valid transmit bit yields a valid output one clock later
    assert_tx_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && rst_n) |=> tx_dout_valid);

    // R3: an idle transmit clock yields no output
    assert_tx_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> !tx_dout_valid);

    // R5: lock only rises after a valid received bit
    assert_lock_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_locked) |-> $past(rx_valid));

    // R8: descrambled output needs a valid bit received while locked
    assert_out_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dout_valid |-> ($past(rx_valid) && $past(rx_locked)));

    // R9: the dropping bit is still presented as descrambled output
    assert_drop_with_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_locked) |-> rx_dout_valid);

    // R10: lock state changes only on valid received bits
    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rx_valid)) |-> $stable(rx_locked));
endmodule

bind line_scrambler scr_checker u_scr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_valid      (tx_valid),
    .tx_dout_valid (tx_dout_valid),
    .rx_valid      (rx_valid),
    .rx_dout_valid (rx_dout_valid),
    .rx_locked     (rx_locked)
);

// File: tb/tb_line_scrambler.sv
`timescale 1ns/1ps
module tb_line_scrambler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0, tx_din = 1'b0;
    logic rx_valid = 1'b0, rx_din = 1'b0;
    logic tx_dout_valid, tx_dout, rx_dout_valid, rx_dout, rx_locked;

    int n_chk = 0;
    int n_err = 0;
    logic exp_tx[$];
    logic exp_rx[$];
    logic [10:0] tx_g;
    logic [10:0] rx_g;
    logic cap [0:2099];
    int   cap_n = 0;
    logic cap_en = 1'b0;

    always #10 clk = ~clk;

    line_scrambler dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_din(tx_din),
        .tx_dout_valid(tx_dout_valid), .tx_dout(tx_dout),
        .rx_valid(rx_valid), .rx_din(rx_din),
        .rx_dout_valid(rx_dout_valid), .rx_dout(rx_dout),
        .rx_locked(rx_locked)
    );

    // Reference sequence from the requirement: x(n) = x(n-11) ^ x(n-9)
    function automatic logic mbit(input logic [10:0] s);
        return s[10] ^ s[8];
    endfunction
    function automatic logic [10:0] mnext(input logic [10:0] s);
        return {s[9:0], s[10] ^ s[8]};
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Monitor: pop and compare as outputs appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_dout_valid) begin
                if (cap_en && cap_n < 2100) begin
                    cap[cap_n] = tx_dout;
                    cap_n++;
                end
                if (exp_tx.size() == 0) chk(1'b1, 1'b0, "R3 unexpected tx_dout_valid");
                else chk(tx_dout, exp_tx.pop_front(), "R2 tx_dout");
            end
            if (rx_dout_valid) begin
                if (exp_rx.size() == 0) chk(1'b1, 1'b0, "R8 unexpected rx_dout_valid");
                else chk(rx_dout, exp_rx.pop_front(), "R7 rx_dout");
            end
        end
    end

    task automatic tx_bit(input logic b);
        @(negedge clk);
        rx_valid = 1'b0;
        tx_valid = 1'b1;
        tx_din   = b;
        exp_tx.push_back(b ^ mbit(tx_g));
        tx_g = mnext(tx_g);
    endtask

    task automatic rx_bit(input logic p, input logic expect_out);
        @(negedge clk);
        tx_valid = 1'b0;
        rx_valid = 1'b1;
        rx_din   = p ^ mbit(rx_g);
        rx_g = mnext(rx_g);
        if (expect_out) exp_rx.push_back(p);
    endtask

    task automatic quiet();
        @(negedge clk);
        tx_valid = 1'b0;
        rx_valid = 1'b0;
    endtask

    // Locked data block: random bits then an idle run that refreshes the check
    task automatic rx_block();
        for (int i = 0; i < 20; i++) begin
            rx_bit(1'($urandom), 1'b1);
            if (i % 7 == 3) quiet();
        end
        for (int i = 0; i < 12; i++) rx_bit(1'b1, 1'b1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        tx_g = '1;
        rx_g = 11'h2C5;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        quiet();
        // R1: reset state
        chk(tx_dout_valid, 1'b0, "R1 tx_dout_valid");
        chk(rx_dout_valid, 1'b0, "R1 rx_dout_valid");
        chk(rx_locked, 1'b0, "R1 rx_locked");

        // R2: first sequence bit after reset is 0, so a plain 1 goes out as 1
        tx_bit(1'b1);
        quiet();
        chk(tx_dout, 1'b1, "R2 first whitened bit");
        // R2/R3: random data with idle gaps that must not advance the sequence
        for (int i = 0; i < 60; i++) begin
            tx_bit(1'($urandom));
            if (i % 5 == 2) begin quiet(); quiet(); end
        end
        quiet();
        quiet();
        chk(tx_dout_valid, 1'b0, "R3 no output while idle");

        // R4: period 2047 on a zero stream
        cap_en = 1'b1;
        for (int i = 0; i < 2060; i++) tx_bit(1'b0);
        quiet();
        quiet();
        cap_en = 1'b0;
        for (int i = 0; i < 11; i++) chk(cap[i + 2047], cap[i], "R4 period 2047");
        chk(1'(cap[0] == cap[1] && cap[1] == cap[2] && cap[2] == cap[3]), 1'b0, "R4 nonconstant");

        // R6/R5: idle stream from an arbitrary phase locks on the 22nd bit
        for (int i = 0; i < 21; i++) begin
            rx_bit(1'b1, 1'b0);
            if (i == 6) quiet();
        end
        quiet();
        chk(rx_locked, 1'b0, "R6 no lock after 21 bits");
        chk(rx_dout_valid, 1'b0, "R8 no output while searching");
        rx_bit(1'b1, 1'b0);
        quiet();
        chk(rx_locked, 1'b1, "R5 lock after 22nd bit");

        // R7/R8: locked descrambling with valid gaps
        for (int b = 0; b < 4; b++) rx_block();
        quiet();
        chk(rx_locked, 1'b1, "R9 lock kept with idle runs");

        // R9: 32 plain zeros exhaust the window; drop shows with last output
        for (int i = 0; i < 31; i++) rx_bit(1'b0, 1'b1);
        quiet();
        chk(rx_locked, 1'b1, "R9 lock held after 31 zeros");
        rx_bit(1'b0, 1'b1);
        quiet();
        chk(rx_dout_valid, 1'b1, "R9 last bit still output");
        chk(rx_locked, 1'b0, "R9 lock dropped on 32nd zero");

        // R11/R10: ones 10 and 11 after the zeros give hypothesis zeros,
        // so the run restarts at one 12 and relock lands on one 22
        for (int i = 0; i < 21; i++) rx_bit(1'b1, 1'b0);
        quiet();
        chk(rx_locked, 1'b0, "R11 run restarted, no lock at 21");
        rx_bit(1'b1, 1'b0);
        quiet();
        chk(rx_locked, 1'b1, "R10 relock at 22nd one");
        for (int b = 0; b < 2; b++) rx_block();
        quiet();
        quiet();
        chk(1'(exp_rx.size() == 0), 1'b1, "R7 all descrambled bits seen");
        chk(1'(exp_tx.size() == 0), 1'b1, "R2 all whitened bits seen");
        summary();
    end
endmodule